// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is an I2C target that sits behind a fixed 7-bit device address and fronts a small bank of 8-bit registers. It runs entirely on the system clock. It oversamples the SCL and SDA pins through a short synchronizer and drives SDA through a single open-drain enable. When the enable is high, the pad pulls SDA low. The block does not stretch the clock.

A write transfer carries two kinds of byte after the address. The first byte selects a register through an internal pointer. Each byte after that is stored at the pointer, and the pointer then advances. A read transfer streams registers out from the current pointer, most significant bit first, for as long as the master acknowledges. A combined transfer uses a repeated START: it first writes the pointer, then turns the bus around and reads. Each stored byte also appears for one cycle on a write strobe port, so that neighbouring logic can watch register updates.

Top module: `i2cp_target`

## Requirements
- R1: After synchronous reset, `sda_oe` and `wr_en` are low, every register holds 0x00 and the pointer is 0.
- R2: A START (SDA falling while SCL is high) in any state, including the middle of a byte, discards the partial byte and restarts address reception. A STOP (SDA rising while SCL is high) discards any partial byte without writing it and leaves SDA released.
- R3: In the first byte after START, bits 7:1 are compared with 1101000 and bit 0 is the direction (0 write, 1 read). On a match, `sda_oe` is high for the whole ninth clock. On a mismatch, nothing is acknowledged, driven or written, and the pointer is unchanged until the next START or STOP.
- R4: After a matching address with write, the next byte loads its low PTR_W bits into the pointer. That byte is acknowledged and is not written to any register.
- R5: Each later byte in the write is acknowledged and stored at the pointer. It produces exactly one `wr_en` cycle with `wr_addr` equal to the pointer and `wr_data` equal to the byte. The pointer then increments, wrapping from DEPTH-1 to 0.
- R6: In a read, the target sends the register at the pointer MSB first, with `sda_oe` high for each 0 bit. The pointer increments after every byte, wrapping from DEPTH-1 to 0. A read that sends no pointer byte starts at the current pointer.
- R7: If the master holds SDA low on the ninth clock (ACK), the target sends the next byte. If SDA is high on that clock (NACK), the target keeps SDA released until the next START or STOP.
- R8: `sda_oe` only ever asserts while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level, as seen on the wired bus |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| wr_en | output | 1 | One-cycle strobe for a stored byte |
| wr_addr | output | PTR_W | Register index of the stored byte |
| wr_data | output | 8 | Value of the stored byte |

## Verification
The bench checks the following corner cases, each of which a faulty design would get wrong in a visible way:
- **Pointer wrap.** The bench writes and reads across the top of the bank. A pointer that fails to wrap reads from or writes to the wrong entry.
- **Aborted bytes.** The bench stops a byte half way with a STOP, and separately with a repeated START. A design that kept its bit count would commit a stray register write or misread the following address.
- **Foreign addresses.** The bench sends non-matching addresses in both directions. These must draw no ACK, no SDA drive and no pointer movement. Releasing SDA only half way here would show up as a low bit on an idle bus.
- **Master NACK.** The bench clocks a full byte after the master's NACK. A target that keeps shifting would pull SDA low and corrupt the STOP.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    // Protocol phase of the target
    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_PTR,
        S_WDATA,
        S_ACK,
        S_RDATA,
        S_MACK,
        S_SKIP
    } phase_e;

    // Synchronized pin levels and the bus events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input byte_t b, input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/i2cp_linesync.sv
module i2cp_linesync
    import i2cp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_d, sda_d;
    logic              scl_now, sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_now = scl_ff[STAGES-1];
    assign sda_now = sda_ff[STAGES-1];

    always_comb begin
        ev.scl      = scl_now;
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_d;
        ev.scl_fall = ~scl_now & scl_d;
        ev.start    = scl_now & scl_d & sda_d & ~sda_now;
        ev.stop     = scl_now & scl_d & ~sda_d & sda_now;
    end

endmodule

// File: rtl/i2cp_regbank.sv
module i2cp_regbank
    import i2cp_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  byte_t            wdata,
    input  logic [PTR_W-1:0] raddr,
    output byte_t            rdata
);

    localparam int DEPTH = 1 << PTR_W;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/i2cp_target.sv
module i2cp_target
    import i2cp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1101000,
    parameter int         PTR_W       = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    bus_ev_t          ev;
    phase_e           phase, after_ack;
    logic [CNT_W-1:0] bitcnt;
    byte_t            shreg;
    byte_t            rd_data;
    logic [PTR_W-1:0] ptr;
    logic             mst_ack;

    i2cp_linesync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cp_regbank #(.PTR_W(PTR_W)) bank_i (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (ptr),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= S_IDLE;
            after_ack <= S_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            ptr       <= '0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            mst_ack   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (ev.stop) begin
                phase  <= S_IDLE;
                sda_oe <= 1'b0;
                bitcnt <= '0;
            end else if (ev.start) begin
                phase  <= S_ADDR;
                sda_oe <= 1'b0;
                bitcnt <= '0;
            end else begin
                case (phase)
                    S_ADDR, S_PTR, S_WDATA: begin
                        if (ev.scl_rise && bitcnt != LAST_BIT) begin
                            shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall && bitcnt == LAST_BIT) begin
                            bitcnt <= '0;
                            if (phase == S_ADDR) begin
                                if (addr_hit(shreg, DEV_ADDR)) begin
                                    sda_oe    <= 1'b1;
                                    phase     <= S_ACK;
                                    after_ack <= shreg[0] ? S_RDATA : S_PTR;
                                end else begin
                                    phase <= S_SKIP;
                                end
                            end else if (phase == S_PTR) begin
                                ptr       <= shreg[PTR_W-1:0];
                                sda_oe    <= 1'b1;
                                phase     <= S_ACK;
                                after_ack <= S_WDATA;
                            end else begin
                                wr_en     <= 1'b1;
                                wr_addr   <= ptr;
                                wr_data   <= shreg;
                                ptr       <= ptr + 1'b1;
                                sda_oe    <= 1'b1;
                                phase     <= S_ACK;
                                after_ack <= S_WDATA;
                            end
                        end
                    end
                    S_ACK: begin
                        if (ev.scl_fall) begin
                            phase  <= after_ack;
                            bitcnt <= '0;
                            if (after_ack == S_RDATA) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    S_RDATA: begin
                        if (ev.scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                phase  <= S_MACK;
                                bitcnt <= '0;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b1};
                                sda_oe <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    S_MACK: begin
                        if (ev.scl_rise) begin
                            mst_ack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mst_ack) begin
                                phase  <= S_RDATA;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                            end else begin
                                phase <= S_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cp_target_chk.sv
module i2cp_target_chk
    import i2cp_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   scl,
    input logic   start,
    input logic   stop,
    input phase_e phase,
    input logic   sda_oe,
    input logic   wr_en
);

    assert_drive_when_low_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl);

    assert_start_rearms_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (phase == S_ADDR));

    assert_stop_releases_R2: assert property (@(posedge clk) disable iff (rst)
        stop |=> (phase == S_IDLE && !sda_oe));

    assert_write_single_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    assert_write_acked_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (phase == S_ACK && sda_oe));

    assert_skip_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == S_SKIP) |-> !sda_oe);

    assert_master_ack_free_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == S_MACK) |-> !sda_oe);

endmodule

bind i2cp_target i2cp_target_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .scl    (ev.scl),
    .start  (ev.start),
    .stop   (ev.stop),
    .phase  (phase),
    .sda_oe (sda_oe),
    .wr_en  (wr_en)
);

// File: tb/i2cp_target_tb_top.sv
module i2cp_target_tb_top;

    localparam int PTR_W = 3;
    localparam int DEPTH = 1 << PTR_W;
    localparam int Q     = 8;
    localparam logic [6:0] DEV = 7'b1101000;

    logic             clk, rst, scl_m, sda_m;
    logic             sda_oe, wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic             sda_line;

    assign sda_line = sda_m & ~sda_oe;

    i2cp_target #(.DEV_ADDR(DEV), .PTR_W(PTR_W)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    int         checks = 0;
    int         errors = 0;
    int         r8_bad = 0;
    bit         done   = 0;
    logic       prev_oe = 0;
    logic [7:0] mdl [DEPTH];
    int         mptr = 0;
    int         expq [$];

    initial begin
        clk = 0;
        forever #10 clk = ~clk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write monitor: every stored byte must match the model's next entry
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            if (expq.size() == 0) begin
                check(0, "R5 unexpected write", {wr_addr, wr_data}, 0);
            end else begin
                int e;
                e = expq.pop_front();
                check({wr_addr, wr_data} == e[PTR_W+7:0], "R5 write addr/data",
                      {wr_addr, wr_data}, e);
            end
        end
        if (!rst && sda_oe && !prev_oe && scl_m) r8_bad++;
        prev_oe <= sda_oe;
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clk_bit(input bit drv, output bit seen);
        sda_m = drv;
        qwait();
        scl_m = 1;
        qwait();
        seen = sda_line;
        qwait();
        scl_m = 0;
        qwait();
    endtask

    task automatic bus_start();
        sda_m = 1;
        qwait();
        scl_m = 1;
        qwait();
        sda_m = 0;
        qwait();
        scl_m = 0;
        qwait();
    endtask

    task automatic bus_stop();
        sda_m = 0;
        qwait();
        scl_m = 1;
        qwait();
        sda_m = 1;
        qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(!mack, s);
    endtask

    task automatic wr_txn(input logic [7:0] p, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2);
        bit a;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        check(a, "R3 address+write ack", a, 1);
        send_byte(p, a);
        check(a, "R4 pointer byte ack", a, 1);
        mptr = p % DEPTH;
        for (int k = 0; k < 3; k++) begin
            expq.push_back((mptr << 8) | d[k]);
            mdl[mptr] = d[k];
            mptr = (mptr + 1) % DEPTH;
            send_byte(d[k], a);
            check(a, "R5 data byte ack", a, 1);
        end
        bus_stop();
        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R5 all writes seen", expq.size(), 0);
    endtask

    // Read n bytes from the current pointer (its START doubles as a repeated START)
    task automatic rd_cur(input int n, input string req);
        bit a, s;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b1}, a);
        check(a, "R3 address+read ack", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            check(b == mdl[mptr], req, b, mdl[mptr]);
            mptr = (mptr + 1) % DEPTH;
        end
        for (int k = 0; k < 8; k++) begin
            clk_bit(1'b1, s);
            check(s == 1'b1, "R7 SDA released after NACK", s, 1);
        end
        bus_stop();
    endtask

    task automatic set_ptr(input logic [7:0] p);
        bit a;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        check(a, "R3 address+write ack", a, 1);
        send_byte(p, a);
        check(a, "R4 pointer byte ack", a, 1);
        mptr = p % DEPTH;
    endtask

    initial begin
        bit a, s;
        logic [7:0] b;
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
        rst = 1; scl_m = 1; sda_m = 1;
        repeat (10) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);
        check(sda_oe == 0, "R1 sda_oe after reset", sda_oe, 0);
        check(wr_en == 0, "R1 wr_en after reset", wr_en, 0);

        // Plain writes, then writes that wrap the pointer (0x0E uses low bits -> 6)
        wr_txn(8'h02, 8'hA5, 8'h3C, 8'h7E);
        wr_txn(8'h0E, 8'h11, 8'h22, 8'h33);

        // Combined format: pointer write, repeated START, read (entry 1 still reset value)
        set_ptr(8'h01);
        rd_cur(4, "R6 combined read data");
        check(mdl[1] == 8'h00, "R1 untouched register reads zero", mdl[1], 0);

        // Read from current pointer, crossing the top of the bank
        rd_cur(4, "R6 read wraps at top");

        // Foreign addresses are ignored
        bus_start();
        send_byte(8'hA0, a);
        check(!a, "R3 foreign write address not acked", a, 0);
        send_byte(8'h05, a);
        check(!a, "R3 no ack after foreign address", a, 0);
        send_byte(8'hFF, a);
        check(!a, "R3 no ack after foreign address", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'hD3, a);
        check(!a, "R3 foreign read address not acked", a, 0);
        for (int k = 0; k < 8; k++) begin
            clk_bit(1'b1, s);
            check(s == 1'b1, "R3 no drive after foreign read", s, 1);
        end
        bus_stop();
        rd_cur(1, "R3 pointer unchanged by foreign transfer");

        // STOP in the middle of a data byte writes nothing
        set_ptr(8'h03);
        for (int k = 0; k < 4; k++) clk_bit(1'b0, s);
        bus_stop();
        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R2 no write on aborted byte", expq.size(), 0);
        set_ptr(8'h03);
        rd_cur(1, "R2 register intact after STOP abort");

        // Repeated START in the middle of a byte restarts address reception
        set_ptr(8'h00);
        for (int k = 0; k < 3; k++) clk_bit(1'b1, s);
        rd_cur(2, "R2 read after mid-byte repeated START");

        repeat (4) @(negedge clk);
        check(r8_bad == 0, "R8 drive only while SCL low", r8_bad, 0);
        check(expq.size() == 0, "R5 no pending writes", expq.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule